// File: doc/BRIEF.md
# Sprite Status Flag Register

This block keeps the one-byte status word that a video display processor returns to its host. The word carries three sticky flags and a five-bit sprite number. The frame flag marks the end of the active picture. The fifth-sprite flag marks a scan line that asked for more sprites than the hardware shows. The collision flag marks two sprites whose pixels met. The sprite number reports which sprite the line scanner was handling when the fifth-sprite flag froze it.

The sprite line scanner feeds the block with the index of the sprite it is looking at, a qualifier for that index, and an overflow event. The pixel stage sends collision candidates together with their column and line. A line-mode input sets how tall the active picture is: 24 rows (192 lines) or 30 rows (240 lines). A host read strobe returns the word and clears every flag. An interrupt request follows the frame flag, gated by an enable input.

A report mode lets the number field keep following the scanner past the overflow event. The field then ends up holding the last and highest sprite processed on the line. This covers a configuration in which all 32 sprites can share one line.

Top module: `sprite_status_reg`

## Requirements
- R1: After reset the status word is 0x00 and the interrupt request is low.
- R2: A one-cycle frame-end pulse sets the frame flag (status bit 7) on the next clock edge, and the flag stays set until a host read.
- R3: An overflow event sets the fifth-sprite flag (status bit 6) on the next edge, and the flag stays set until a host read.
- R4: While the fifth-sprite flag is 0, every cycle with a valid scan index or an overflow event loads that index into the number field (bits 4..0), visible one cycle later.
- R5: In normal report mode (max_rpt_i = 0), the number field does not change while the fifth-sprite flag is 1.
- R6: A collision candidate sets the collision flag (status bit 5) only when its column is below 256 and its line is inside the active picture.
- R7: The active picture ends before line 192 when row30_i = 0 and before line 240 when row30_i = 1.
- R8: A host read clears all three flags on the next edge, even when a set event for the same flag arrives in that cycle.
- R9: Once a host read has cleared the fifth-sprite flag, the number field follows the scanned index again from the next cycle.
- R10: With max_rpt_i = 1, the number field follows the scanned index whatever the fifth-sprite flag holds.
- R11: irq_o is high exactly when the frame flag is 1 and int_en_i is 1.
- R12: A host read leaves the number field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_end_i | input | 1 | One-cycle pulse at the end of active display |
| scan_valid_i | input | 1 | scan_idx_i holds the sprite being scanned |
| scan_idx_i | input | 5 | Index of the sprite being scanned |
| too_many_i | input | 1 | Overflow event for the sprite in scan_idx_i |
| coll_hit_i | input | 1 | Collision candidate pulse |
| coll_x_i | input | 9 | Column of the candidate pixel |
| coll_line_i | input | 9 | Line of the candidate pixel |
| row30_i | input | 1 | 1 selects 240 active lines, 0 selects 192 |
| max_rpt_i | input | 1 | 1 lets the number field follow the scanner past the overflow |
| rd_stb_i | input | 1 | Host status read strobe |
| int_en_i | input | 1 | Interrupt enable |
| status_o | output | 8 | {frame, fifth, collision, number[4:0]} |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties check on every cycle that a read clears the flags and that a set without a read sticks. They also check that the number field holds still while it is frozen, that it follows the scan index while it is free, that a rise of the collision flag comes from a candidate inside the visible window, and that the interrupt never fires without the frame flag and its enable. Some cases show only in the bench's scenarios: the exact column and line boundaries in both line modes, reads that collide with set events, the number field taking up tracking again after a mid-frame read, and the report mode in which the number runs past the overflow. The bench's reference model catches every field of the word drifting on any cycle of those scenarios.

// File: rtl/sprite_status_pkg.sv
package sprite_status_pkg;

  // flag positions inside the flag vector (status bits above the number)
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned COLL_BIT  = 0;
  localparam int unsigned FIFTH_BIT = 1;
  localparam int unsigned FRAME_BIT = 2;

endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;

endmodule

// File: rtl/ss_flag_bank.sv
module ss_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < int'(N); g++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic flag_en;

    // the clear term dominates any set arriving in the same cycle
    always_comb begin
      flag_en = clr_i | set_i[g];
      flag_d  = clr_i ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_en) begin
        flag_q <= flag_d;
      end
    end

    assign flag_o[g] = flag_q;
  end

endmodule

// File: rtl/ss_coll_window.sv
module ss_coll_window #(
  parameter int unsigned X_W         = 9,
  parameter int unsigned Y_W         = 9,
  parameter int unsigned H_ACTIVE    = 256,
  parameter int unsigned LINES_SHORT = 192,
  parameter int unsigned LINES_TALL  = 240
) (
  input  logic           hit_i,
  input  logic [X_W-1:0] x_i,
  input  logic [Y_W-1:0] line_i,
  input  logic           tall_i,
  output logic           valid_o
);

  localparam logic [X_W-1:0] X_LIM     = X_W'(H_ACTIVE);
  localparam logic [Y_W-1:0] Y_LIM_S   = Y_W'(LINES_SHORT);
  localparam logic [Y_W-1:0] Y_LIM_T   = Y_W'(LINES_TALL);

  logic [Y_W-1:0] y_lim;
  logic           col_on;
  logic           row_on;

  always_comb begin
    y_lim   = tall_i ? Y_LIM_T : Y_LIM_S;
    col_on  = (x_i < X_LIM);
    row_on  = (line_i < y_lim);
    valid_o = hit_i & col_on & row_on;
  end

endmodule

// File: rtl/ss_num_track.sv
module ss_num_track #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             freeze_i,
  output logic [IDX_W-1:0] num_o
);

  logic [IDX_W-1:0] num_q;
  logic [IDX_W-1:0] num_d;
  logic             num_en;

  always_comb begin
    num_en = sample_i & ~freeze_i;
    num_d  = idx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
    end else if (num_en) begin
      num_q <= num_d;
    end
  end

  assign num_o = num_q;

endmodule

// File: rtl/sprite_status_reg.sv
module sprite_status_reg
  import sprite_status_pkg::*;
#(
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned X_W         = 9,
  parameter int unsigned Y_W         = 9,
  parameter int unsigned H_ACTIVE    = 256,
  parameter int unsigned LINES_SHORT = 192,
  parameter int unsigned LINES_TALL  = 240,
  localparam int unsigned STAT_W     = NUM_FLAGS + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end_i,
  input  logic              scan_valid_i,
  input  logic [IDX_W-1:0]  scan_idx_i,
  input  logic              too_many_i,
  input  logic              coll_hit_i,
  input  logic [X_W-1:0]    coll_x_i,
  input  logic [Y_W-1:0]    coll_line_i,
  input  logic              row30_i,
  input  logic              max_rpt_i,
  input  logic              rd_stb_i,
  input  logic              int_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);

  logic                 rst_q_n;
  logic                 coll_ok;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;
  logic                 num_freeze;
  logic                 num_sample;
  logic [IDX_W-1:0]     num;

  ss_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  ss_coll_window #(
    .X_W         (X_W),
    .Y_W         (Y_W),
    .H_ACTIVE    (H_ACTIVE),
    .LINES_SHORT (LINES_SHORT),
    .LINES_TALL  (LINES_TALL)
  ) u_win (
    .hit_i   (coll_hit_i),
    .x_i     (coll_x_i),
    .line_i  (coll_line_i),
    .tall_i  (row30_i),
    .valid_o (coll_ok)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FRAME_BIT] = frame_end_i;
    set_vec[FIFTH_BIT] = too_many_i;
    set_vec[COLL_BIT]  = coll_ok;
  end

  ss_flag_bank #(
    .N (NUM_FLAGS)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (set_vec),
    .clr_i  (rd_stb_i),
    .flag_o (flags)
  );

  // the number latch freezes on the registered flag, so a read that clears
  // the flag frees it from the following cycle on
  always_comb begin
    num_freeze = flags[FIFTH_BIT] & ~max_rpt_i;
    num_sample = scan_valid_i | too_many_i;
  end

  ss_num_track #(
    .IDX_W (IDX_W)
  ) u_num (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sample_i (num_sample),
    .idx_i    (scan_idx_i),
    .freeze_i (num_freeze),
    .num_o    (num)
  );

  always_comb begin
    status_o = {flags[FRAME_BIT], flags[FIFTH_BIT], flags[COLL_BIT], num};
    irq_o    = flags[FRAME_BIT] & int_en_i;
  end

endmodule

// File: rtl/sprite_status_chk.sv
module sprite_status_chk #(
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned X_W         = 9,
  parameter int unsigned Y_W         = 9,
  parameter int unsigned H_ACTIVE    = 256,
  parameter int unsigned LINES_SHORT = 192,
  parameter int unsigned LINES_TALL  = 240
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               frame_end_i,
  input logic               scan_valid_i,
  input logic [IDX_W-1:0]   scan_idx_i,
  input logic               too_many_i,
  input logic               coll_hit_i,
  input logic [X_W-1:0]     coll_x_i,
  input logic [Y_W-1:0]     coll_line_i,
  input logic               row30_i,
  input logic               max_rpt_i,
  input logic               rd_stb_i,
  input logic               int_en_i,
  input logic [IDX_W+2:0]   status_o,
  input logic               irq_o
);

  localparam int unsigned TOP = IDX_W + 2;

  logic in_window;
  always_comb begin
    in_window = coll_hit_i
              && (int'(coll_x_i) < int'(H_ACTIVE))
              && (int'(coll_line_i) < (row30_i ? int'(LINES_TALL) : int'(LINES_SHORT)));
  end

  // R8
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_stb_i |=> (status_o[TOP -: 3] == 3'b000));

  // R2
  frame_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (frame_end_i && !rd_stb_i) |=> status_o[TOP]);

  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status_o[TOP] && !rd_stb_i) |=> status_o[TOP]);

  // R3
  fifth_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (too_many_i && !rd_stb_i) |=> status_o[TOP-1]);

  // R4
  num_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!status_o[TOP-1] && scan_valid_i) |=> (status_o[IDX_W-1:0] == $past(scan_idx_i)));

  // R5
  num_frozen_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status_o[TOP-1] && !max_rpt_i) |=> $stable(status_o[IDX_W-1:0]));

  // R6
  coll_cause_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(status_o[TOP-2]) |-> $past(in_window));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o |-> (status_o[TOP] && int_en_i));

endmodule

bind sprite_status_reg sprite_status_chk #(
  .IDX_W       (IDX_W),
  .X_W         (X_W),
  .Y_W         (Y_W),
  .H_ACTIVE    (H_ACTIVE),
  .LINES_SHORT (LINES_SHORT),
  .LINES_TALL  (LINES_TALL)
) chk_i (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .frame_end_i  (frame_end_i),
  .scan_valid_i (scan_valid_i),
  .scan_idx_i   (scan_idx_i),
  .too_many_i   (too_many_i),
  .coll_hit_i   (coll_hit_i),
  .coll_x_i     (coll_x_i),
  .coll_line_i  (coll_line_i),
  .row30_i      (row30_i),
  .max_rpt_i    (max_rpt_i),
  .rd_stb_i     (rd_stb_i),
  .int_en_i     (int_en_i),
  .status_o     (status_o),
  .irq_o        (irq_o)
);

// File: tb/sprite_status_reg_tb.sv
`timescale 1ns/1ps
module sprite_status_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_end_i = 1'b0;
  logic       scan_valid_i = 1'b0;
  logic [4:0] scan_idx_i = '0;
  logic       too_many_i = 1'b0;
  logic       coll_hit_i = 1'b0;
  logic [8:0] coll_x_i = '0;
  logic [8:0] coll_line_i = '0;
  logic       row30_i = 1'b0;
  logic       max_rpt_i = 1'b0;
  logic       rd_stb_i = 1'b0;
  logic       int_en_i = 1'b0;
  logic [7:0] status_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  sprite_status_reg dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end_i  (frame_end_i),
    .scan_valid_i (scan_valid_i),
    .scan_idx_i   (scan_idx_i),
    .too_many_i   (too_many_i),
    .coll_hit_i   (coll_hit_i),
    .coll_x_i     (coll_x_i),
    .coll_line_i  (coll_line_i),
    .row30_i      (row30_i),
    .max_rpt_i    (max_rpt_i),
    .rd_stb_i     (rd_stb_i),
    .int_en_i     (int_en_i),
    .status_o     (status_o),
    .irq_o        (irq_o)
  );

  // behavioural reference, written from the requirements
  bit m_frame = 0, m_fifth = 0, m_coll = 0;
  int m_num = 0;
  int sync_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt = 0;
      m_frame = 0; m_fifth = 0; m_coll = 0; m_num = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt = sync_cnt + 1;
      m_frame = 0; m_fifth = 0; m_coll = 0; m_num = 0;
    end else begin
      int lim;
      bit hit_ok;
      lim = row30_i ? 240 : 192;
      hit_ok = coll_hit_i && (int'(coll_x_i) < 256) && (int'(coll_line_i) < lim);
      if ((scan_valid_i || too_many_i) && (!m_fifth || max_rpt_i)) m_num = int'(scan_idx_i);
      if (rd_stb_i) begin
        m_frame = 0; m_fifth = 0; m_coll = 0;
      end else begin
        m_frame = m_frame | frame_end_i;
        m_fifth = m_fifth | too_many_i;
        m_coll  = m_coll | hit_ok;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R2 frame bit", int'(status_o[7]), int'(m_frame));
      check("R3 fifth bit", int'(status_o[6]), int'(m_fifth));
      check("R6 collision bit", int'(status_o[5]), int'(m_coll));
      check("R4 number field", int'(status_o[4:0]), m_num);
      check("R11 irq", int'(irq_o), int'(m_frame && int_en_i));
    end
  end

  task automatic step();
    @(negedge clk);
    frame_end_i = 0; too_many_i = 0; coll_hit_i = 0; rd_stb_i = 0; scan_valid_i = 0;
  endtask

  task automatic scan(input int idx, input bit over);
    scan_valid_i = 1; scan_idx_i = 5'(idx); too_many_i = over;
    step();
  endtask

  task automatic coll(input int x, input int ln);
    coll_hit_i = 1; coll_x_i = 9'(x); coll_line_i = 9'(ln);
    step();
  endtask

  task automatic rd();
    rd_stb_i = 1;
    step();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status after reset", int'(status_o), 0);
    check("R1 irq after reset", int'(irq_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 status after release", int'(status_o), 0);

    // R2 / R11 frame flag and interrupt
    int_en_i = 1;
    frame_end_i = 1; step();
    check("R2 frame set", int'(status_o[7]), 1);
    check("R11 irq enabled", int'(irq_o), 1);
    int_en_i = 0; step();
    check("R11 irq gated", int'(irq_o), 0);
    repeat (5) step();
    check("R2 frame held", int'(status_o[7]), 1);
    rd();
    check("R8 frame cleared by read", int'(status_o[7]), 0);

    // R4 tracking, R3 overflow, R5 freeze
    for (int i = 0; i < 4; i++) begin
      scan(i, 0);
      check("R4 number follows scan", int'(status_o[4:0]), i);
    end
    scan(4, 1);
    check("R3 fifth set", int'(status_o[6]), 1);
    check("R4 number at overflow", int'(status_o[4:0]), 4);
    for (int i = 5; i < 32; i++) scan(i, 0);
    check("R5 number frozen", int'(status_o[4:0]), 4);
    scan(7, 1);
    check("R5 number frozen on second overflow", int'(status_o[4:0]), 4);

    // R12 read leaves number, R9 resume after read
    rd();
    check("R8 fifth cleared", int'(status_o[6]), 0);
    check("R12 number kept over read", int'(status_o[4:0]), 4);
    scan(9, 0);
    check("R9 number resumes", int'(status_o[4:0]), 9);

    // R8 read racing with set events
    rd_stb_i = 1; too_many_i = 1; scan_valid_i = 1; scan_idx_i = 5'd12; frame_end_i = 1;
    coll_hit_i = 1; coll_x_i = 9'd10; coll_line_i = 9'd10; step();
    check("R8 clear beats sets", int'(status_o[7:5]), 0);
    check("R4 number sampled with cleared overflow", int'(status_o[4:0]), 12);

    // R6 / R7 collision window
    row30_i = 0;
    coll(256, 10);
    check("R6 column 256 ignored", int'(status_o[5]), 0);
    coll(100, 192);
    check("R7 line 192 ignored in 24-row mode", int'(status_o[5]), 0);
    coll(255, 191);
    check("R6 last visible pixel counts", int'(status_o[5]), 1);
    rd();
    row30_i = 1;
    coll(0, 240);
    check("R7 line 240 ignored in 30-row mode", int'(status_o[5]), 0);
    coll(0, 239);
    check("R7 line 239 counts in 30-row mode", int'(status_o[5]), 1);
    rd();
    check("R8 collision cleared", int'(status_o[5]), 0);

    // R10 highest-sprite report mode
    max_rpt_i = 1;
    scan(3, 1);
    check("R3 fifth set in report mode", int'(status_o[6]), 1);
    for (int i = 4; i < 32; i++) scan(i, 0);
    check("R10 number reaches last sprite", int'(status_o[4:0]), 31);
    max_rpt_i = 0;
    scan(2, 0);
    check("R5 freeze back in normal mode", int'(status_o[4:0]), 31);
    rd();
    repeat (2) step();
    finish_run();
  end

endmodule